// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block watches the control pins of one SDRAM bank on every clock: chip select, the three strobes and the clock enable. It decodes the pins into a command and follows the bank through its states: idle, row active, precharging, auto-refreshing, self-refresh and power-down. For each command it reports whether that command is allowed in the state the bank is in. A command that is accepted but has no effect is not flagged. A command that is not allowed raises a flag in the cycle it appears.

The precharge recovery time and the auto-refresh time are parameters given in clock cycles. One shared down-counter times both. The bank returns to idle when that counter runs out. Self-refresh and power-down are entered from idle when the clock enable is low in the same cycle. They are left when the clock enable goes high again. A controller model or a bus monitor can place the block beside a memory port to catch protocol errors as they happen.

Top module: `sdram_bank_checker`

## Requirements
- R1: Decoding. With cs_n high the command is deselect (code 0). With cs_n low, {ras_n,cas_n,we_n} decodes as: 111 NOP (1), 110 burst stop (2), 101 read (3), 100 write (4), 011 activate (5), 010 precharge (6), 001 refresh (7), 000 mode register set (8). cmd_o carries the code.
- R2: While rst_n is low, state_o is idle (0) and illegal_o is low, whatever the pins carry.
- R3: In idle (0) with cke high, deselect, NOP, burst stop, precharge and mode register set are accepted and the bank stays idle. Read and write are illegal.
- R4: Activate in idle with cke high moves the bank to row active (1). In row active, read, write, burst stop, NOP and deselect are accepted. Activate, refresh and mode register set are illegal.
- R5: Precharge in row active moves the bank to precharging (2). The bank shows precharging for exactly TRP cycles and then shows idle. The commands issued in between do not change this.
- R6: In precharging, deselect, NOP, burst stop and precharge are no-ops. Read, write, activate, refresh and mode register set are illegal.
- R7: Refresh with cke high in idle moves the bank to refreshing (3) for exactly TRFC cycles, then to idle. While refreshing, only deselect and NOP are accepted.
- R8: Refresh with cke low in idle enters self-refresh (4). The bank stays there while cke is low. Commands there are ignored and never flagged. A cycle with cke high moves the bank to idle at the next edge.
- R9: Deselect or NOP with cke low in idle enters power-down (5). Commands there are ignored and never flagged. A cycle with cke high moves the bank to idle at the next edge.
- R10: cke low is illegal in row active, precharging and refreshing. In idle, cke low is illegal with any command other than refresh, deselect or NOP.
- R11: illegal_o is high in the same cycle as the offending command and low otherwise. An illegal command leaves the state unchanged. Timed recovery keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable of the bank |
| state_o | output | 3 | Bank state: 0 idle, 1 row active, 2 precharging, 3 refreshing, 4 self-refresh, 5 power-down |
| cmd_o | output | 4 | Decoded command code (see R1) |
| illegal_o | output | 1 | High in the cycle of an illegal command |

## Verification
The bench builds the block with TRP=3 and TRFC=5. These values are short enough to place an illegal command and a no-op in separate cycles inside one precharge window. They also make it possible to count the exact cycle in which each timed state ends. Because the two recovery times differ, a wrong load value on the shared counter shows up as a wrong state length. The full decode table is exercised inside self-refresh, where no command can change the state.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ACT   = 3'd1,
      ST_PRECH = 3'd2,
      ST_REFR  = 3'd3,
      ST_SELF  = 3'd4,
      ST_PDOWN = 3'd5
   } bank_state_t;

   typedef enum logic [3:0] {
      CMD_DESL = 4'd0,
      CMD_NOP  = 4'd1,
      CMD_BST  = 4'd2,
      CMD_RD   = 4'd3,
      CMD_WR   = 4'd4,
      CMD_ACT  = 4'd5,
      CMD_PRE  = 4'd6,
      CMD_REF  = 4'd7,
      CMD_MRS  = 4'd8
   } bank_cmd_t;

endpackage

// File: rtl/sdb_cmd_decode.sv
module sdb_cmd_decode
   import sdb_pkg::*;
(
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   output bank_cmd_t cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b110:  cmd = CMD_BST;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdb_rule_table.sv
module sdb_rule_table
   import sdb_pkg::*;
(
   input  bank_state_t state,
   input  bank_cmd_t   cmd,
   input  logic        cke,
   output logic        illegal,
   output bank_state_t req_state,
   output logic        tmr_load,
   output logic        tmr_sel_ref
);

   always_comb begin
      illegal     = 1'b0;
      req_state   = state;
      tmr_load    = 1'b0;
      tmr_sel_ref = 1'b0;
      case (state)
         ST_IDLE: begin
            if (cke) begin
               case (cmd)
                  CMD_RD, CMD_WR: illegal = 1'b1;
                  CMD_ACT:        req_state = ST_ACT;
                  CMD_REF: begin
                     req_state   = ST_REFR;
                     tmr_load    = 1'b1;
                     tmr_sel_ref = 1'b1;
                  end
                  default: ;
               endcase
            end else begin
               case (cmd)
                  CMD_REF:           req_state = ST_SELF;
                  CMD_DESL, CMD_NOP: req_state = ST_PDOWN;
                  default:           illegal = 1'b1;
               endcase
            end
         end
         ST_ACT: begin
            if (!cke) begin
               illegal = 1'b1;
            end else begin
               case (cmd)
                  CMD_PRE: begin
                     req_state = ST_PRECH;
                     tmr_load  = 1'b1;
                  end
                  CMD_ACT, CMD_REF, CMD_MRS: illegal = 1'b1;
                  default: ;
               endcase
            end
         end
         ST_PRECH: begin
            if (!cke) begin
               illegal = 1'b1;
            end else begin
               case (cmd)
                  CMD_DESL, CMD_NOP, CMD_BST, CMD_PRE: ;
                  default: illegal = 1'b1;
               endcase
            end
         end
         ST_REFR: begin
            if (!cke || !(cmd == CMD_DESL || cmd == CMD_NOP)) illegal = 1'b1;
         end
         ST_SELF, ST_PDOWN: begin
            if (cke) req_state = ST_IDLE;
         end
         default: req_state = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/sdb_timer.sv
module sdb_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
   import sdb_pkg::*;
#(
   parameter int TRP  = 4,
   parameter int TRFC = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       cke,
   output logic [2:0] state_o,
   output logic [3:0] cmd_o,
   output logic       illegal_o
);

   localparam int MAXT = (TRP > TRFC) ? TRP : TRFC;
   localparam int CW   = $clog2(MAXT + 1);
   localparam logic [CW-1:0] LD_PRE = CW'(TRP - 1);
   localparam logic [CW-1:0] LD_REF = CW'(TRFC - 1);

   generate
      if (TRP < 1) begin : g_bad_trp
         $error("TRP must be at least one cycle");
      end
      if (TRFC < 1) begin : g_bad_trfc
         $error("TRFC must be at least one cycle");
      end
   endgenerate

   bank_cmd_t   cmd;
   bank_state_t state_q, state_d, req_state;
   logic        illegal, tmr_load, tmr_sel_ref, tmr_zero;

   sdb_cmd_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   sdb_rule_table u_rules (
      .state      (state_q),
      .cmd        (cmd),
      .cke        (cke),
      .illegal    (illegal),
      .req_state  (req_state),
      .tmr_load   (tmr_load),
      .tmr_sel_ref(tmr_sel_ref)
   );

   sdb_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_sel_ref ? LD_REF : LD_PRE),
      .zero    (tmr_zero)
   );

   always_comb begin
      state_d = req_state;
      if ((state_q == ST_PRECH || state_q == ST_REFR) && tmr_zero) state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o   = state_q;
   assign cmd_o     = cmd;
   assign illegal_o = illegal & rst_n;

endmodule

// File: rtl/sdb_sva.sv
module sdb_sva
   import sdb_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic [2:0] state,
   input logic [3:0] cmd,
   input logic       illegal
);

   AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal && (state == ST_IDLE || state == ST_ACT) |=> $stable(state)); // R11
   AST_IDLE_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && cke && (cmd == CMD_RD || cmd == CMD_WR) |-> illegal); // R3
   AST_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ACT && $past(state) != ST_ACT |-> $past(state) == ST_IDLE); // R4
   AST_PRE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_PRECH && cke && (cmd == CMD_BST || cmd == CMD_PRE) |-> !illegal); // R6
   AST_SELF_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SELF && !cke |=> state == ST_SELF); // R8
   AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SELF && cke |=> state == ST_IDLE); // R8
   AST_SELF_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SELF && $past(state) != ST_SELF |-> $past(state) == ST_IDLE); // R8
   AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_PDOWN && cke |=> state == ST_IDLE); // R9
   AST_LOWPWR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SELF || state == ST_PDOWN) |-> !illegal); // R9
   AST_CKE_LOW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ACT && !cke |-> illegal); // R10

endmodule

bind sdram_bank_checker sdb_sva u_sva (
   .clk    (clk),
   .rst_n  (rst_n),
   .cke    (cke),
   .state  (state_o),
   .cmd    (cmd_o),
   .illegal(illegal_o)
);

// File: tb/sdram_bank_checker_bench.sv
`timescale 1ns/1ps
module sdram_bank_checker_bench;

   localparam int TRP  = 3;
   localparam int TRFC = 5;

   localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4,
                  C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8;
   localparam int S_IDLE = 0, S_ACT = 1, S_PRECH = 2, S_REFR = 3, S_SELF = 4, S_PDOWN = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [2:0] state_o;
   logic [3:0] cmd_o;
   logic       illegal_o;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   sdram_bank_checker #(.TRP(TRP), .TRFC(TRFC)) u_sdram_bank_checker (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .cke(cke), .state_o(state_o), .cmd_o(cmd_o), .illegal_o(illegal_o)
   );

   function automatic logic [3:0] pins(input int c);
      case (c)
         C_DESL:  return 4'b1111;
         C_NOP:   return 4'b0111;
         C_BST:   return 4'b0110;
         C_RD:    return 4'b0101;
         C_WR:    return 4'b0100;
         C_ACT:   return 4'b0011;
         C_PRE:   return 4'b0010;
         C_REF:   return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic drive(input int c, input logic ck);
      @(negedge clk);
      cke = ck;
      {cs_n, ras_n, cas_n, we_n} = pins(c);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset;
      drive(C_RD, 1'b1);
      chk("R2 state in reset", state_o, S_IDLE);
      chk("R2 illegal in reset", illegal_o, 0);
      rst_n = 1'b1;
      drive(C_NOP, 1'b1);
      chk("R2 state after reset", state_o, S_IDLE);
      chk("R2 illegal after reset", illegal_o, 0);
   endtask

   task automatic t_idle;
      int ok_cmds[5] = '{C_DESL, C_NOP, C_BST, C_PRE, C_MRS};
      foreach (ok_cmds[i]) begin
         drive(ok_cmds[i], 1'b1);
         chk("R3 accepted in idle", illegal_o, 0);
         drive(C_NOP, 1'b1);
         chk("R3 stays idle", state_o, S_IDLE);
      end
      drive(C_RD, 1'b1);
      chk("R3 read illegal in idle", illegal_o, 1);
      drive(C_WR, 1'b1);
      chk("R3 write illegal in idle", illegal_o, 1);
      chk("R11 state unchanged by read", state_o, S_IDLE);
      drive(C_NOP, 1'b1);
      chk("R11 state unchanged by write", state_o, S_IDLE);
      chk("R11 flag drops", illegal_o, 0);
   endtask

   task automatic t_decode_self;
      drive(C_REF, 1'b0);
      chk("R8 self entry legal", illegal_o, 0);
      drive(C_NOP, 1'b0);
      chk("R8 in self-refresh", state_o, S_SELF);
      for (int c = 0; c <= 8; c++) begin
         drive(c, 1'b0);
         chk("R1 decode", cmd_o, c);
         chk("R8 no flag in self", illegal_o, 0);
         chk("R8 stays in self", state_o, S_SELF);
      end
      drive(C_NOP, 1'b1);
      chk("R8 exit takes effect at edge", state_o, S_SELF);
      drive(C_NOP, 1'b1);
      chk("R8 idle after exit", state_o, S_IDLE);
   endtask

   task automatic t_active;
      drive(C_ACT, 1'b1);
      chk("R4 activate legal", illegal_o, 0);
      drive(C_RD, 1'b1);
      chk("R4 row active", state_o, S_ACT);
      chk("R4 read legal", illegal_o, 0);
      drive(C_WR, 1'b1);
      chk("R4 write legal", illegal_o, 0);
      drive(C_ACT, 1'b1);
      chk("R4 activate illegal", illegal_o, 1);
      drive(C_REF, 1'b1);
      chk("R4 refresh illegal", illegal_o, 1);
      drive(C_MRS, 1'b1);
      chk("R4 mode set illegal", illegal_o, 1);
      drive(C_REF, 1'b0);
      chk("R10 cke low in active", illegal_o, 1);
      drive(C_NOP, 1'b1);
      chk("R11 still active", state_o, S_ACT);
   endtask

   task automatic t_precharge;
      drive(C_PRE, 1'b1);
      chk("R4 precharge legal", illegal_o, 0);
      drive(C_BST, 1'b1);
      chk("R5 precharging 1", state_o, S_PRECH);
      chk("R6 burst stop no-op", illegal_o, 0);
      drive(C_RD, 1'b1);
      chk("R5 precharging 2", state_o, S_PRECH);
      chk("R6 read illegal", illegal_o, 1);
      drive(C_PRE, 1'b1);
      chk("R5 precharging 3", state_o, S_PRECH);
      chk("R6 precharge no-op", illegal_o, 0);
      drive(C_NOP, 1'b1);
      chk("R5 idle after TRP", state_o, S_IDLE);
      drive(C_ACT, 1'b1);
      drive(C_PRE, 1'b1);
      drive(C_ACT, 1'b1);
      chk("R6 activate illegal", illegal_o, 1);
      drive(C_REF, 1'b1);
      chk("R6 refresh illegal", illegal_o, 1);
      drive(C_MRS, 1'b1);
      chk("R6 mode set illegal", illegal_o, 1);
      drive(C_NOP, 1'b1);
      chk("R11 timer not stretched", state_o, S_IDLE);
      drive(C_ACT, 1'b1);
      drive(C_PRE, 1'b1);
      drive(C_WR, 1'b1);
      chk("R6 write illegal", illegal_o, 1);
      drive(C_NOP, 1'b0);
      chk("R10 cke low in precharging", illegal_o, 1);
      drive(C_DESL, 1'b1);
      chk("R6 deselect no-op", illegal_o, 0);
      chk("R5 still precharging", state_o, S_PRECH);
      drive(C_NOP, 1'b1);
      chk("R5 idle again", state_o, S_IDLE);
   endtask

   task automatic t_refresh;
      int seq[5] = '{C_NOP, C_ACT, C_DESL, C_BST, C_NOP};
      int exp_ill[5] = '{0, 1, 0, 1, 0};
      drive(C_REF, 1'b1);
      chk("R7 refresh legal", illegal_o, 0);
      foreach (seq[i]) begin
         drive(seq[i], 1'b1);
         chk("R7 refreshing", state_o, S_REFR);
         chk("R7 legality while refreshing", illegal_o, exp_ill[i]);
      end
      drive(C_NOP, 1'b1);
      chk("R7 idle after TRFC", state_o, S_IDLE);
   endtask

   task automatic t_pdown;
      drive(C_NOP, 1'b0);
      chk("R9 power-down entry legal", illegal_o, 0);
      drive(C_DESL, 1'b0);
      chk("R9 in power-down", state_o, S_PDOWN);
      drive(C_RD, 1'b0);
      chk("R9 ignored in power-down", illegal_o, 0);
      chk("R9 stays in power-down", state_o, S_PDOWN);
      drive(C_NOP, 1'b1);
      chk("R9 exit takes effect at edge", state_o, S_PDOWN);
      drive(C_NOP, 1'b1);
      chk("R9 idle after exit", state_o, S_IDLE);
      drive(C_ACT, 1'b0);
      chk("R10 cke low with activate in idle", illegal_o, 1);
      drive(C_NOP, 1'b1);
      chk("R11 idle kept", state_o, S_IDLE);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_idle();
      t_decode_self();
      t_active();
      t_precharge();
      t_refresh();
      t_pdown();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule